// File: doc/BRIEF.md
# Banked RAM Expansion Page Mapper

This block extends a 64K-address, 8-bit processor system to as much as 1M of RAM, split into 64K pages. An 8-bit control register sits at one decoded I/O address. Software writes it to choose a 64K page inside a 256K bank, to choose one of four 256K banks, to decide whether video fetches follow that choice, and to set the size of a low common address window. The register is readable back on the data bus and resets to all ones.

For each access the mapper combines the register, the top four CPU address bits and a video-fetch flag. It produces a 2-bit within-bank page line value and four active-low, one-hot bank strobes. A "force default" override takes the access to a fixed default page and bank. The override fires when the address falls in the common window, or when the video chip owns the bus and video is tied to the default bank.

The page lines are an inverted copy of the register bits. The all-ones reset value and the override therefore both reach page 3. A build parameter chooses where the override sends the 256K bank select:
- In the layered scheme, the override goes to the lowest bank.
- In the linear scheme, the override goes to the highest bank, which is the same bank that reset selects.

A second output decodes the expansion-mode bits.

Top module: `xram_bank_map`

## Requirements
- R1: After reset the control register holds 8'hFF, and a read at the register address returns 8'hFF.
- R2: A write with `cpuWe`=1 at `REG_ADDR` loads `cpuWrData` into the register at that clock edge. A write at any other address leaves the register unchanged.
- R3: `rdHit` is 1 only when `cpuAddr` equals `REG_ADDR`, and `rdData` is 8'h00 whenever `rdHit` is 0.
- R4: With no override, `pageLine` equals the bitwise inverse of register bits [1:0]. Bits 11 give lines 00, which is page 3, and bits 00 give lines 11.
- R5: With no override and `accessEn`=1, strobe `bankStrbN[k]` is low, with k given by register bits [3:2] taken as an unsigned number, and the other three strobes are high.
- R6: With register bit 6=1 and bit 7=1, the override fires for every address with `cpuAddr[15:14]`=00.
- R7: With register bit 6=1 and bit 7=0, the override fires only for addresses with `cpuAddr[15:12]`=0000.
- R8: With register bit 6=0, the override fires exactly when `vidFetch`=1, whatever the address. With bit 6=1, `vidFetch` has no effect on the override.
- R9: During an override, `pageLine` is 00 and bits [3:0] are ignored. The strobe that goes low is `bankStrbN[0]` when `LINEAR`=0, and `bankStrbN[3]` when `LINEAR`=1.
- R10: With `accessEn`=0, all four strobes are high. With `accessEn`=1, exactly one strobe is low.
- R11: `altMode` is 1 exactly when register bit 4 is 1 and bit 5 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | Address of the current access |
| cpuWrData | input | 8 | Write data for the control register |
| cpuWe | input | 1 | CPU write strobe |
| vidFetch | input | 1 | 1 while the video chip owns the bus |
| accessEn | input | 1 | 1 during a valid memory cycle |
| rdData | output | 8 | Register readback; 0 when the address is not the register address |
| rdHit | output | 1 | The address matches the register address |
| pageLine | output | 2 | Page line value within the 256K bank (inverted encoding) |
| bankStrbN | output | 4 | Active-low one-hot 256K bank strobes |
| altMode | output | 1 | Alternate expansion mode selected |

## Verification
The bench builds two copies side by side on the same inputs: one with `LINEAR`=0 and one with `LINEAR`=1. Both keep the default register address. With both copies present, the only behaviour that separates the two schemes can be checked: where the override sends the bank select, compared against where reset sends it. Every one of the 256 register values is written and then crossed with all sixteen upper-address nibbles and both video-flag states. This reaches every override path and every page and bank encoding.

// File: rtl/xram_pkg.sv
package xram_pkg;
  localparam int XR_PAGE_W = 2;
  localparam int XR_BANK_W = 2;
  localparam int XR_NUM_BANKS = 1 << XR_BANK_W;

  // control register bit positions (decoded by the mapper)
  localparam int XR_B_PAGE = 0;
  localparam int XR_B_BANK = 2;
  localparam int XR_B_MODEA = 4;
  localparam int XR_B_MODEB = 5;
  localparam int XR_B_VID = 6;
  localparam int XR_B_WIN = 7;

  typedef struct packed {
    logic                 forceDef;
    logic                 strobeEn;
    logic [XR_PAGE_W-1:0] pageBits;
    logic [XR_BANK_W-1:0] bankIdx;
    logic                 altMode;
  } xram_ctl_t;
endpackage

// File: rtl/xram_ctrl.sv
module xram_ctrl
  import xram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFD16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuWe,
  input  logic              vidFetch,
  input  logic              accessEn,
  output logic [DATA_W-1:0] regQ,
  output logic              regHit,
  output xram_ctl_t         ctl
);
  localparam int WIDE_BITS = 2;
  localparam int NARROW_BITS = 4;

  logic inWideWin, inNarrowWin, winForce, vidForce;

  assign regHit = (cpuAddr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) regQ <= '1;
    else if (cpuWe && regHit) regQ <= cpuWrData;
  end

  assign inWideWin = (cpuAddr[ADDR_W-1 -: WIDE_BITS] == '0);
  assign inNarrowWin = (cpuAddr[ADDR_W-1 -: NARROW_BITS] == '0);
  assign winForce = regQ[XR_B_VID] && (regQ[XR_B_WIN] ? inWideWin : inNarrowWin);
  assign vidForce = !regQ[XR_B_VID] && vidFetch;

  always_comb begin
    ctl.forceDef = winForce || vidForce;
    ctl.strobeEn = accessEn;
    ctl.pageBits = regQ[XR_B_PAGE +: XR_PAGE_W];
    ctl.bankIdx = regQ[XR_B_BANK +: XR_BANK_W];
    ctl.altMode = regQ[XR_B_MODEA] && !regQ[XR_B_MODEB];
  end

  // R1: register is all ones in the first cycle after reset
  assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> regQ == '1);

  // R2: a hit write lands on the next edge
  assert_write_update_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && regHit) |=> regQ == $past(cpuWrData));

  // R2: anything else leaves the register alone
  assert_write_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuWe && regHit) |=> $stable(regQ));
endmodule

// File: rtl/xram_map.sv
module xram_map
  import xram_pkg::*;
#(
  parameter bit LINEAR = 1'b0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  xram_ctl_t               ctl,
  output logic [XR_PAGE_W-1:0]    pageLine,
  output logic [XR_NUM_BANKS-1:0] bankStrbN,
  output logic                    altMode
);
  localparam logic [XR_BANK_W-1:0] DEF_BANK =
    LINEAR ? XR_BANK_W'(XR_NUM_BANKS - 1) : '0;

  logic [XR_BANK_W-1:0] selIdx;

  assign selIdx = ctl.forceDef ? DEF_BANK : ctl.bankIdx;
  assign pageLine = ctl.forceDef ? '0 : ~ctl.pageBits;
  assign altMode = ctl.altMode;

  for (genvar i = 0; i < XR_NUM_BANKS; i++) begin : g_strb
    assign bankStrbN[i] = !(ctl.strobeEn && (selIdx == XR_BANK_W'(i)));
  end

  // R10: exactly one strobe during a valid cycle
  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.strobeEn |-> $countones(~bankStrbN) == 1);

  // R10: no strobe while idle
  assert_idle_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.strobeEn |-> bankStrbN == '1);

  // R9: override lands on page 3 (lines 00)
  assert_force_page_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.forceDef |-> pageLine == '0);

  // R9: override lands on the scheme's default bank
  assert_force_bank_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.forceDef && ctl.strobeEn) |-> !bankStrbN[DEF_BANK]);
endmodule

// File: rtl/xram_bank_map.sv
module xram_bank_map
  import xram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFD16,
  parameter bit LINEAR = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuWe,
  input  logic              vidFetch,
  input  logic              accessEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdHit,
  output logic [1:0]        pageLine,
  output logic [3:0]        bankStrbN,
  output logic              altMode
);
  logic [DATA_W-1:0] regQ;
  xram_ctl_t ctl;

  xram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWe(cpuWe), .vidFetch(vidFetch), .accessEn(accessEn),
    .regQ(regQ), .regHit(rdHit), .ctl(ctl)
  );

  xram_map #(.LINEAR(LINEAR)) u_map (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .pageLine(pageLine), .bankStrbN(bankStrbN), .altMode(altMode)
  );

  assign rdData = rdHit ? regQ : '0;
endmodule

// File: tb/xram_bank_map_test.sv
module xram_bank_map_test;
  localparam logic [15:0] RA = 16'hFD16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0] cpuWrData = '0;
  logic cpuWe = 1'b0, vidFetch = 1'b0, accessEn = 1'b1;
  logic [7:0] rdData, rdDataL;
  logic rdHit, rdHitL, altMode, altModeL;
  logic [1:0] pageLine, pageLineL;
  logic [3:0] bankStrbN, bankStrbNL;

  int nChk = 0, nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xram_bank_map #(.LINEAR(1'b0)) uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWe(cpuWe), .vidFetch(vidFetch), .accessEn(accessEn),
    .rdData(rdData), .rdHit(rdHit), .pageLine(pageLine),
    .bankStrbN(bankStrbN), .altMode(altMode));

  xram_bank_map #(.LINEAR(1'b1)) uutLin (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWe(cpuWe), .vidFetch(vidFetch), .accessEn(accessEn),
    .rdData(rdDataL), .rdHit(rdHitL), .pageLine(pageLineL),
    .bankStrbN(bankStrbNL), .altMode(altModeL));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit refForce(input logic [7:0] r, input logic [3:0] nib, input bit vid);
    if (r[6]) return r[7] ? (nib[3:2] == 2'b00) : (nib == 4'h0);
    return vid;
  endfunction

  function automatic logic [3:0] refStrb(input logic [7:0] r, input bit f, input bit lin, input bit en);
    int idx;
    if (!en) return 4'hF;
    idx = f ? (lin ? 3 : 0) : int'(r[3:2]);
    return ~(4'b0001 << idx);
  endfunction

  task automatic writeReg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWe = 1'b1;
    @(negedge clk);
    cpuWe = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [7:0] exp);
    @(negedge clk);
    cpuAddr = RA;
    #2;
    check(req, rdData, exp);
    check(req, rdDataL, exp);
    check(req, {7'd0, rdHit}, 8'd1);
  endtask

  task automatic testReset();
    readCheck("R1 reset readback", 8'hFF);
    cpuAddr = 16'h8000; vidFetch = 0; accessEn = 1;
    #1;
    check("R1 reset page", {6'd0, pageLine}, 8'h00);
    check("R1 reset bank", {4'd0, bankStrbN}, 8'h07);
    check("R1 reset bank linear", {4'd0, bankStrbNL}, 8'h07);
  endtask

  task automatic testWrite();
    writeReg(RA, 8'h5A);
    readCheck("R2 write readback", 8'h5A);
    writeReg(RA + 16'd1, 8'h00);
    readCheck("R2 off-address write ignored", 8'h5A);
    writeReg(16'h0000, 8'hFF);
    readCheck("R2 off-address write ignored", 8'h5A);
  endtask

  task automatic testReadDecode();
    foreach (cpuAddr[i]) begin
      @(negedge clk);
      cpuAddr = RA ^ (16'd1 << i);
      #2;
      check("R3 miss hit flag", {7'd0, rdHit}, 8'd0);
      check("R3 miss data", rdData, 8'h00);
    end
  endtask

  task automatic testSweep();
    for (int r = 0; r < 256; r++) begin
      writeReg(RA, 8'(r));
      for (int n = 0; n < 16; n++) begin
        for (int v = 0; v < 2; v++) begin
          logic [7:0] rv;
          bit f;
          rv = 8'(r);
          cpuAddr = {4'(n), 12'h5A5};
          vidFetch = v[0];
          accessEn = 1'b1;
          #1;
          f = refForce(rv, 4'(n), v[0]);
          if (!f) check("R4 page lines", {6'd0, pageLine}, {6'd0, ~rv[1:0]});
          else check("R9 forced page", {6'd0, pageLine}, 8'h00);
          if (rv[6] && rv[7]) check("R6 wide window", {4'd0, bankStrbN}, {4'd0, refStrb(rv, f, 0, 1)});
          else if (rv[6]) check("R7 narrow window", {4'd0, bankStrbN}, {4'd0, refStrb(rv, f, 0, 1)});
          else check("R8 video override", {4'd0, bankStrbN}, {4'd0, refStrb(rv, f, 0, 1)});
          if (!f) check("R5 bank select", {4'd0, bankStrbN}, {4'd0, refStrb(rv, 0, 0, 1)});
          check("R9 linear scheme", {4'd0, bankStrbNL}, {4'd0, refStrb(rv, f, 1, 1)});
          check("R4 linear page", {6'd0, pageLineL}, f ? 8'h00 : {6'd0, ~rv[1:0]});
          check("R11 mode decode", {7'd0, altMode}, {7'd0, rv[4] & ~rv[5]});
          #1;
        end
      end
    end
  endtask

  task automatic testIdle();
    writeReg(RA, 8'h4B);
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      cpuAddr = {4'(n), 12'h000};
      accessEn = 1'b0;
      #1;
      check("R10 idle no strobe", {4'd0, bankStrbN}, 8'h0F);
      check("R10 idle no strobe linear", {4'd0, bankStrbNL}, 8'h0F);
      accessEn = 1'b1;
      #1;
      check("R10 active single strobe", 8'($countones(~bankStrbN)), 8'd1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWrite();
    testReadDecode();
    testSweep();
    testIdle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule